// File: doc/BRIEF.md
# Clock/RAM Chip Host Register Bridge

This block sits on a simple processor bus and exposes two byte registers: a data register and a control register. They are used to exchange single bytes with an external clock and battery-backed RAM chip. Software loads the data register first. It then writes the control register with the start bit set, together with a direction bit and a chip-select bit. The bridge runs one byte exchange that lasts a fixed, parameterised number of clock cycles, which models the serial shift time. During the exchange the start bit reads back as 1, so software polls it as a busy flag. When the exchange ends the bit clears. On a read, the byte returned by the chip is then in the data register.

The direction bit and the chip-select bit keep their values from one exchange to the next. A multi-byte command sequence therefore needs only the start bit to be set again for each byte. Clearing the chip-select bit deselects the chip and ends the sequence. The low four bits of the control register hold an unrelated display setting. They are plain storage that the exchange never touches.

Top module: `rtcb_bridge`

## Requirements
- R1: After reset the data register reads 0x00, the control register reads 0x00, and both chip_en and chip_strobe are 0.
- R2: The data register is at BASE_ADDR and the control register is at BASE_ADDR+1. The control register reads as {busy (bit 7), direction (bit 6), chip select (bit 5), 0 (bit 4), display nibble (bits 3:0)}. Any other address reads 0x00, and a write to it changes neither register.
- R3: A control write with bit 7 = 1 while idle starts an exchange. Bit 7 then reads 1 for exactly XFER_CYCLES cycles after the write edge and reads 0 afterwards.
- R4: chip_strobe is high for exactly one cycle, the first busy cycle. Throughout the exchange chip_rnw equals bit 6 and chip_wdata equals the data register.
- R5: With bit 6 = 1 (read), the data register holds the value chip_rdata had in the last busy cycle once the exchange ends. With bit 6 = 0 (write), the data register is unchanged.
- R6: Writes to the data register during an exchange are ignored.
- R7: During an exchange a control write cannot change bits 7:5. Writing 0 to bit 7 does not abort the exchange. Bits 3:0 are still updated.
- R8: The exchange never changes bits 3:0. Bits 6 and 5 keep their values after an exchange ends.
- R9: chip_en follows bit 5 from the cycle after the control write that sets or clears it.
- R10: A control write with bit 7 = 0 while idle starts no exchange: bit 7 stays 0 and no strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational from address |
| chip_en | output | 1 | Chip select (control bit 5) |
| chip_strobe | output | 1 | One-cycle pulse starting a byte exchange |
| chip_rnw | output | 1 | Exchange direction, 1 = read from chip |
| chip_wdata | output | 8 | Byte sent to the chip |
| chip_rdata | input | 8 | Byte returned by the chip |

## Verification
A control write takes effect at the clock edge where bus_we is high. The busy bit and chip_strobe can be seen in the half cycle that follows. The bench samples at every falling edge after the start and expects busy = 1 in exactly XFER_CYCLES samples, with the strobe in the first of them. The result of a read is due in the data register at the first falling edge after busy clears, and it is checked there. Bus reads are combinational, so each one is sampled 1 ns after the address is driven at a falling edge. Writes that must be ignored are issued inside the busy window, and both registers are read back before the next stimulus.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
   localparam int BYTE_W    = 8;
   localparam int BIT_START = 7;
   localparam int BIT_RNW   = 6;
   localparam int BIT_EN    = 5;
   localparam int BIT_ZERO  = 4;
   localparam int NIB_W     = 4;

   typedef struct packed {
      logic             busy;
      logic             rnw;
      logic             en;
      logic             zero;
      logic [NIB_W-1:0] nib;
   } ctl_view_t;
endpackage

// File: rtl/rtcb_addr_dec.sv
module rtcb_addr_dec #(
   parameter int ADDR_W    = 16,
   parameter int BASE_ADDR = 16'h0040
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_data,
   output logic              hit_ctl
);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(BASE_ADDR + 1);

   if (ADDR_W < 2) begin : g_bad_w
      $error("rtcb_addr_dec: ADDR_W must be at least 2");
   end
   if (BASE_ADDR < 0 || BASE_ADDR + 1 >= (1 << ADDR_W)) begin : g_bad_base
      $error("rtcb_addr_dec: BASE_ADDR+1 must fit in ADDR_W bits");
   end

   always_comb begin
      hit_data = (addr == DATA_A);
      hit_ctl  = (addr == CTL_A);
   end
endmodule

// File: rtl/rtcb_ctl_reg.sv
module rtcb_ctl_reg
   import rtcb_pkg::*;
#(
   parameter int XFER_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic [BYTE_W-1:0] wdata,
   output logic              busy,
   output logic              rnw,
   output logic              en,
   output logic [NIB_W-1:0]  nib,
   output logic              done,
   output logic              strobe
);
   logic start_req;

   if (XFER_CYCLES < 1) begin : g_bad_len
      $error("rtcb_ctl_reg: XFER_CYCLES must be at least 1");
   end

   assign start_req = wr_ctl && wdata[BIT_START] && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         rnw    <= 1'b0;
         en     <= 1'b0;
         nib    <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= start_req;
         if (start_req)
            busy <= 1'b1;
         else if (done)
            busy <= 1'b0;
         if (wr_ctl && !busy) begin
            rnw <= wdata[BIT_RNW];
            en  <= wdata[BIT_EN];
         end
         if (wr_ctl)
            nib <= wdata[NIB_W-1:0];
      end
   end

   if (XFER_CYCLES == 1) begin : g_single
      assign done = busy;
   end else begin : g_timer
      localparam int CNT_W = $clog2(XFER_CYCLES);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (start_req)
            cnt <= CNT_W'(XFER_CYCLES - 1);
         else if (busy && cnt != '0)
            cnt <= cnt - 1'b1;
      end
      assign done = busy && (cnt == '0);
   end

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> busy); // R3
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R3
   AST_STROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> strobe); // R4
   AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe); // R4
   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable({rnw, en})); // R7
   AST_NIB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctl |=> $stable(nib)); // R8
endmodule

// File: rtl/rtcb_data_reg.sv
module rtcb_data_reg
   import rtcb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              busy,
   input  logic              done,
   input  logic              rnw,
   input  logic [BYTE_W-1:0] chip_rdata,
   output logic [BYTE_W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         data <= '0;
      else if (done && rnw)
         data <= chip_rdata;
      else if (wr_data && !busy)
         data <= wdata;
   end

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> $stable(data)); // R6
   AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      done && rnw |=> data == $past(chip_rdata)); // R5
   AST_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      done && !rnw |=> $stable(data)); // R5
endmodule

// File: rtl/rtcb_bridge.sv
module rtcb_bridge
   import rtcb_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int BASE_ADDR   = 16'h0040,
   parameter int XFER_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              chip_en,
   output logic              chip_strobe,
   output logic              chip_rnw,
   output logic [7:0]        chip_wdata,
   input  logic [7:0]        chip_rdata
);
   logic             hit_data, hit_ctl;
   logic             busy, rnw, en, done, strobe;
   logic [NIB_W-1:0] nib;
   logic [BYTE_W-1:0] data;
   ctl_view_t        view;

   rtcb_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr(bus_addr), .hit_data(hit_data), .hit_ctl(hit_ctl));

   rtcb_ctl_reg #(.XFER_CYCLES(XFER_CYCLES)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_ctl(bus_we && hit_ctl),
      .wdata(bus_wdata), .busy(busy), .rnw(rnw), .en(en), .nib(nib),
      .done(done), .strobe(strobe));

   rtcb_data_reg u_data (
      .clk(clk), .rst_n(rst_n), .wr_data(bus_we && hit_data),
      .wdata(bus_wdata), .busy(busy), .done(done), .rnw(rnw),
      .chip_rdata(chip_rdata), .data(data));

   always_comb begin
      view = '{busy: busy, rnw: rnw, en: en, zero: 1'b0, nib: nib};
      if (hit_data)
         bus_rdata = data;
      else if (hit_ctl)
         bus_rdata = view;
      else
         bus_rdata = '0;
   end

   assign chip_en     = en;
   assign chip_strobe = strobe;
   assign chip_rnw    = rnw;
   assign chip_wdata  = data;

   AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |=> $stable(chip_wdata)); // R4
   AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && hit_ctl && !busy |=> chip_en == $past(bus_wdata[BIT_EN])); // R9
endmodule

// File: tb/test_rtcb_bridge.sv
`timescale 1ns/1ps
module test_rtcb_bridge;
   localparam int AW = 16;
   localparam int BASE = 16'h0040;
   localparam int N = 8;
   localparam logic [AW-1:0] A_DATA = AW'(BASE);
   localparam logic [AW-1:0] A_CTL  = AW'(BASE + 1);

   logic clk = 0, rst_n = 0;
   logic [AW-1:0] bus_addr = '0;
   logic bus_we = 0;
   logic [7:0] bus_wdata = 0, bus_rdata, chip_wdata, chip_rdata = 0;
   logic chip_en, chip_strobe, chip_rnw;
   int tests = 0, fails = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   rtcb_bridge #(.ADDR_W(AW), .BASE_ADDR(BASE), .XFER_CYCLES(N)) i_rtcb_bridge (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chip_en(chip_en),
      .chip_strobe(chip_strobe), .chip_rnw(chip_rnw), .chip_wdata(chip_wdata),
      .chip_rdata(chip_rdata));

   function automatic logic [7:0] ctl_exp(bit b, bit r, bit e, logic [3:0] n);
      return {b, r, e, 1'b0, n};
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   // shadow state
   logic [7:0] s_data;
   bit s_rnw, s_en;
   logic [3:0] s_nib;

   task automatic run_xfer(logic [7:0] d, bit r, bit e, logic [3:0] n, logic [7:0] cval);
      logic [7:0] v;
      int ones;
      wr(A_DATA, d); s_data = d;
      chip_rdata = cval;
      wr(A_CTL, {1'b1, r, e, 1'b0, n});
      s_rnw = r; s_en = e; s_nib = n;
      ones = 0;
      for (int k = 0; k < N; k++) begin
         rd(A_CTL, v);
         if (v[7]) ones++;
         check("R4 strobe", {7'b0, chip_strobe}, {7'b0, (k == 0)});
         check("R4 rnw/wdata", {chip_rnw, 7'b0} ^ (chip_wdata & 8'h00), {s_rnw, 7'b0});
         check("R4 wdata", chip_wdata, s_data);
         @(negedge clk);
      end
      check("R3 busy cycles", 8'(ones), 8'(N));
      rd(A_CTL, v);
      check("R3 busy cleared / R8 ctl kept", v, ctl_exp(0, s_rnw, s_en, s_nib));
      if (r) s_data = cval;
      chip_rdata = ~cval;
      rd(A_DATA, v);
      check(r ? "R5 read result" : "R5 write keeps data", v, s_data);
      check("R9 chip_en", {7'b0, chip_en}, {7'b0, s_en});
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      int seed = 32'h1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      rd(A_DATA, v); check("R1 data reset", v, 8'h00);
      rd(A_CTL, v);  check("R1 ctl reset", v, 8'h00);
      check("R1 chip pins", {6'b0, chip_en, chip_strobe}, 8'h00);

      // R2 layout, bit 4 reads 0
      wr(A_DATA, 8'hA5); wr(A_CTL, 8'h1C);
      rd(A_DATA, v); check("R2 data at base", v, 8'hA5);
      rd(A_CTL, v);  check("R2 ctl layout bit4 zero / R10", v, ctl_exp(0, 0, 0, 4'hC));
      check("R10 no strobe", {7'b0, chip_strobe}, 8'h00);
      wr(AW'(BASE + 2), 8'hFF);
      rd(AW'(BASE + 2), v); check("R2 other addr reads 0", v, 8'h00);
      rd(A_DATA, v); check("R2 other addr no effect data", v, 8'hA5);
      rd(A_CTL, v);  check("R2 other addr no effect ctl", v, ctl_exp(0, 0, 0, 4'hC));
      s_data = 8'hA5; s_nib = 4'hC; s_rnw = 0; s_en = 0;

      // R9 chip select set and cleared
      wr(A_CTL, 8'h20 | 8'(s_nib));
      check("R9 chip_en set", {7'b0, chip_en}, 8'h01);
      wr(A_CTL, 8'h00 | 8'(s_nib));
      check("R9 chip_en cleared", {7'b0, chip_en}, 8'h00);

      // directed: one write and one read exchange
      run_xfer(8'h3C, 0, 1, 4'h5, 8'h99);
      run_xfer(8'h00, 1, 1, 4'h5, 8'hE7);

      // R6 / R7: writes during an exchange
      wr(A_DATA, 8'h11); s_data = 8'h11;
      chip_rdata = 8'h42;
      wr(A_CTL, 8'hA3);          // start, write, enable, nib 3
      wr(A_DATA, 8'h77);         // ignored
      wr(A_CTL, 8'h4E);          // bit7=0, rnw=1, en=0: ignored; nib=E
      rd(A_CTL, v); check("R7 mode bits held, nib updated", v, ctl_exp(1, 0, 1, 4'hE));
      check("R6 chip_wdata held", chip_wdata, 8'h11);
      rd(A_DATA, v); check("R6 data write ignored", v, 8'h11);
      repeat (N) @(negedge clk);
      rd(A_CTL, v); check("R7 not aborted then done", v, ctl_exp(0, 0, 1, 4'hE));
      rd(A_DATA, v); check("R6 data after exchange", v, 8'h11);
      s_rnw = 0; s_en = 1; s_nib = 4'hE;

      // random exchanges
      for (int i = 0; i < 30; i++) begin
         run_xfer(8'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom));
      end

      // R10 idle control write without start
      wr(A_CTL, 8'h65);
      rd(A_CTL, v); check("R10 no start", v, ctl_exp(0, 1, 1, 4'h5));
      check("R10 no strobe after write", {7'b0, chip_strobe}, 8'h00);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule